// File: doc/BRIEF.md
# 24-bit Multi-Mode Counter/Timer Channel

This block is one channel of a 24-bit up/down counter/timer. Software controls it through four 16-bit registers. One register is the mode word. One is a combined low-word register that loads a preload value and reads back the count. One is a high-word register that does the same for bits 23:16. The last is a control register that takes one-cycle command bits. The count can advance on three kinds of event: a free-running internal timebase, a quadrature encoder decoded at one, two or four counts per cycle, or the rising edges of the encoder A input used as an external clock.

The counter can run all the time, be stopped, or be gated by hardware. The hardware gate is either the gate pin, its inverse, or the inverse of the capture flag. The capture flag goes high on every terminal count. Reload choices are: from preload 0 on terminal count, alternating between the two preloads on terminal count, or from preload 0 on a rising index edge. With these choices, one mode word gives a software-fired one-shot, a pulse train whose two intervals can differ, or a position counter with index reset. The output pin shows either the capture flag or a one-cycle terminal-count pulse, with selectable polarity.

Top module: `tmr24_core`

## Requirements
- R1: After a synchronous reset, the mode word is 0, the count is 0, the capture flag is 1 and `cnt_out` is 1.
- R2: addr 0 writes and reads back the whole mode word. Writes to addr 1 go to the low 16 bits of a preload, and writes to addr 2 go to its bits 23:16 from wdata[7:0]; wdata[15:8] is ignored. The mode bit 14 picks the preload: 0 selects preload 0, 1 selects preload 1.
- R3: A write to addr 3 is a command. Bit 15 clears the count. Bit 14 loads the count from preload 0 and wins over bit 15. Bit 3 clears the capture flag. The count does not advance in a cycle that holds a command write.
- R4: Mode bit 13 = 0: reading addr 1 returns the live count bits 15:0 and stores the full count in a snapshot. Reading addr 2 returns snapshot bits 23:16 in [7:0], with [15:8] = 0. Mode bit 13 = 1: the snapshot is taken on each rising index edge, and both words read from it.
- R5: The enable field is mode bits 8:7. 0 stops the count and 1 runs it. 2 or 3 uses the hardware source in bits 6:5: 0 is the gate pin, 1 is the inverted gate pin, and 2 or 3 is the inverted capture flag.
- R6: The clock source is mode bits 10:9. Code 3 counts one step per internal timebase tick. When the direction-control bit 12 is 1, bit 11 sets the direction: 0 counts up and 1 counts down.
- R7: With bit 12 = 0 and clock source 0, 1 or 2, the encoder is decoded at x1, x2 or x4, and the phase order sets the direction. When A and B change in the same sample, no step is made.
- R8: With bit 12 = 1 and clock source 0, 1 or 2, each synchronized rising edge of enc_a is one step, in the direction set by software.
- R9: A step taken at 0 while counting down, or at 0xFFFFFF while counting up, is a terminal count. It sets the capture flag and produces a one-cycle terminal pulse. With reload code 0 the count wraps.
- R10: The reload code is mode bits 4:2. Code 1 reloads preload 0 on terminal count. Code 2 loads preload 1 and preload 0 in turn, starting with preload 1 after a load command. Code 4 loads preload 0 on a rising index edge, whether or not counting is enabled.
- R11: `cnt_out` is the capture flag when mode bit 0 = 0, or the terminal pulse when bit 0 = 1. It is inverted when mode bit 1 = 1.
- R12: Reading addr 3 returns the capture flag in bit 0 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational, zero when idle) |
| enc_a | input | 1 | Encoder phase A / external clock |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index |
| gate_in | input | 1 | Hardware enable pin |
| cnt_out | output | 1 | Counter output |

## Verification
Most wrong internal states show at the count readback or at `cnt_out` within a few cycles. A wrong preload alternation moves the pulse-train pulses away from their computed cycles on the first reload. A capture flag stuck at the wrong value shows on `cnt_out` in the cycle after the command. A snapshot taken on the wrong event gives a high word that disagrees with the low word read earlier, and this shows on the next high-word read. Faults in decode direction or synchronization show as a count that is off by a known number after a fixed sequence of encoder phases.

// File: rtl/tmr24_pkg.sv
`timescale 1ns/1ps
package tmr24_pkg;
    localparam int WORD_W = 16;

    // mode word, MSB first (bit 15 down to bit 0)
    typedef struct packed {
        logic       rsvd;      // 15
        logic       pr_sel;    // 14
        logic       latch_ext; // 13
        logic       dir_sw;    // 12
        logic       dir_down;  // 11
        logic [1:0] clk_sel;   // 10:9
        logic [1:0] en_ctl;    // 8:7
        logic [1:0] hw_src;    // 6:5
        logic [2:0] reload;    // 4:2
        logic       out_pol;   // 1
        logic       out_src;   // 0
    } mode_t;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_CNT_LO = 2'd1,
        REG_CNT_HI = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] CK_X1 = 2'd0;
    localparam logic [1:0] CK_X2 = 2'd1;
    localparam logic [1:0] CK_X4 = 2'd2;
    localparam logic [1:0] CK_TB = 2'd3;

    localparam logic [2:0] RLD_TERM  = 3'd1;
    localparam logic [2:0] RLD_ALT   = 3'd2;
    localparam logic [2:0] RLD_INDEX = 3'd4;

    localparam int CMD_CLEAR  = 15;
    localparam int CMD_LOAD   = 14;
    localparam int CMD_CAPCLR = 3;

    typedef struct packed {
        logic any;
        logic clear;
        logic load;
        logic capclr;
    } cmd_t;

    typedef struct packed {
        logic valid;
        logic down;
    } step_t;

    // previous and current synchronized phases -> count step
    function automatic step_t quad_decode(input logic pa, input logic pb,
                                          input logic a, input logic b,
                                          input logic [1:0] sel);
        step_t s;
        logic  da;
        logic  db;
        da = pa ^ a;
        db = pb ^ b;
        s  = '0;
        if (da ^ db) begin
            case (sel)
                CK_X1: begin
                    if (da && !b) begin
                        s.valid = 1'b1;
                        s.down  = !a;
                    end
                end
                CK_X2: begin
                    if (da) begin
                        s.valid = 1'b1;
                        s.down  = (a == b);
                    end
                end
                CK_X4: begin
                    s.valid = 1'b1;
                    s.down  = da ? (a == b) : (a != b);
                end
                default: s = '0;
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/tmr24_sync.sv
`timescale 1ns/1ps
module tmr24_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr24_evt.sv
`timescale 1ns/1ps
module tmr24_evt import tmr24_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       a,
    input  logic       b,
    input  logic       idx,
    input  logic [1:0] clk_sel,
    output step_t      qstep,
    output logic       a_rise,
    output logic       idx_rise
);
    logic pa_q;
    logic pb_q;
    logic pi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q <= 1'b0;
            pb_q <= 1'b0;
            pi_q <= 1'b0;
        end else begin
            pa_q <= a;
            pb_q <= b;
            pi_q <= idx;
        end
    end

    assign qstep    = quad_decode(pa_q, pb_q, a, b, clk_sel);
    assign a_rise   = a & ~pa_q;
    assign idx_rise = idx & ~pi_q;
endmodule

// File: rtl/tmr24_regs.sv
`timescale 1ns/1ps
module tmr24_regs import tmr24_pkg::*; #(
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CW-1:0]     count,
    input  logic              cap,
    input  logic              idx_rise,
    output mode_t             mode,
    output logic [CW-1:0]     pre0,
    output logic [CW-1:0]     pre1,
    output cmd_t              cmd,
    output logic [WORD_W-1:0] rdata
);
    localparam int HI_W  = CW - WORD_W;
    localparam int PAD_W = 2 * WORD_W - CW;

    reg_sel_e               sel;
    logic [1:0][CW-1:0]     pre_q;
    logic [CW-1:0]          snap_q;
    logic                   snap_take;

    assign sel = reg_sel_e'(addr);

    assign snap_take = mode.latch_ext ? idx_rise
                                      : (rd_en && sel == REG_CNT_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            pre_q  <= '0;
            snap_q <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    REG_MODE:   mode <= mode_t'(wdata);
                    REG_CNT_LO: pre_q[mode.pr_sel][WORD_W-1:0] <= wdata;
                    REG_CNT_HI: pre_q[mode.pr_sel][CW-1:WORD_W] <= wdata[HI_W-1:0];
                    default: ;
                endcase
            end
            if (snap_take) begin
                snap_q <= count;
            end
        end
    end

    assign pre0 = pre_q[0];
    assign pre1 = pre_q[1];

    always_comb begin
        cmd.any    = wr_en && (sel == REG_CTRL);
        cmd.clear  = cmd.any && wdata[CMD_CLEAR];
        cmd.load   = cmd.any && wdata[CMD_LOAD];
        cmd.capclr = cmd.any && wdata[CMD_CAPCLR];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                REG_MODE:   rdata = mode;
                REG_CNT_LO: rdata = mode.latch_ext ? snap_q[WORD_W-1:0]
                                                   : count[WORD_W-1:0];
                REG_CNT_HI: rdata = {{PAD_W{1'b0}}, snap_q[CW-1:WORD_W]};
                default:    rdata = {{(WORD_W-1){1'b0}}, cap};
            endcase
        end
    end
endmodule

// File: rtl/tmr24_cnt.sv
`timescale 1ns/1ps
module tmr24_cnt import tmr24_pkg::*; #(
    parameter int CW     = 24,
    parameter int TB_DIV = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  logic [CW-1:0] pre0,
    input  logic [CW-1:0] pre1,
    input  cmd_t          cmd,
    input  step_t         qstep,
    input  logic          a_rise,
    input  logic          idx_rise,
    input  logic          gate,
    output logic [CW-1:0] count,
    output logic          cap,
    output logic          tc
);
    localparam int            TB_W = (TB_DIV > 1) ? $clog2(TB_DIV) : 1;
    localparam logic [TB_W-1:0] TB_LAST = TB_W'(TB_DIV - 1);
    localparam logic [CW-1:0] CNT_TOP = '1;

    logic [TB_W-1:0] tb_q;
    logic            alt_q;
    logic            tick;
    logic            run;
    step_t           src;
    logic            at_end;
    logic            adv;
    logic            idx_load;

    assign tick = (tb_q == TB_LAST);

    always_comb begin
        case (mode.en_ctl)
            2'd0: run = 1'b0;
            2'd1: run = 1'b1;
            default: begin
                case (mode.hw_src)
                    2'd0:    run = gate;
                    2'd1:    run = ~gate;
                    default: run = ~cap;
                endcase
            end
        endcase
    end

    always_comb begin
        if (mode.clk_sel == CK_TB) begin
            src.valid = tick;
            src.down  = mode.dir_down;
        end else if (mode.dir_sw) begin
            src.valid = a_rise;
            src.down  = mode.dir_down;
        end else begin
            src = qstep;
        end
    end

    assign adv      = run && src.valid;
    assign at_end   = src.down ? (count == '0) : (count == CNT_TOP);
    assign idx_load = (mode.reload == RLD_INDEX) && idx_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q  <= '0;
            count <= '0;
            cap   <= 1'b1;
            alt_q <= 1'b0;
            tc    <= 1'b0;
        end else begin
            tb_q <= tick ? '0 : tb_q + TB_W'(1);
            tc   <= 1'b0;
            if (cmd.any) begin
                if (cmd.clear) begin
                    count <= '0;
                    alt_q <= 1'b0;
                end
                if (cmd.load) begin
                    count <= pre0;
                    alt_q <= 1'b0;
                end
                if (cmd.capclr) begin
                    cap <= 1'b0;
                end
            end else if (idx_load) begin
                count <= pre0;
                alt_q <= 1'b0;
            end else if (adv) begin
                if (at_end) begin
                    tc  <= 1'b1;
                    cap <= 1'b1;
                    case (mode.reload)
                        RLD_TERM: count <= pre0;
                        RLD_ALT: begin
                            count <= alt_q ? pre0 : pre1;
                            alt_q <= ~alt_q;
                        end
                        default: count <= src.down ? count - CW'(1) : count + CW'(1);
                    endcase
                end else begin
                    count <= src.down ? count - CW'(1) : count + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tmr24_core.sv
`timescale 1ns/1ps
module tmr24_core import tmr24_pkg::*; #(
    parameter int CW          = 24,
    parameter int TB_DIV      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        enc_a,
    input  logic        enc_b,
    input  logic        enc_idx,
    input  logic        gate_in,
    output logic        cnt_out
);
    mode_t          mode_q;
    logic [CW-1:0]  pre0;
    logic [CW-1:0]  pre1;
    cmd_t           cmd;
    logic [CW-1:0]  count_q;
    logic           cap_q;
    logic           tc_q;
    logic [3:0]     pins_s;
    step_t          qstep;
    logic           a_rise;
    logic           idx_rise;

    tmr24_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({gate_in, enc_idx, enc_b, enc_a}),
        .q   (pins_s)
    );

    tmr24_evt u_evt (
        .clk      (clk),
        .rst      (rst),
        .a        (pins_s[0]),
        .b        (pins_s[1]),
        .idx      (pins_s[2]),
        .clk_sel  (mode_q.clk_sel),
        .qstep    (qstep),
        .a_rise   (a_rise),
        .idx_rise (idx_rise)
    );

    tmr24_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .count    (count_q),
        .cap      (cap_q),
        .idx_rise (idx_rise),
        .mode     (mode_q),
        .pre0     (pre0),
        .pre1     (pre1),
        .cmd      (cmd),
        .rdata    (rdata)
    );

    tmr24_cnt #(.CW(CW), .TB_DIV(TB_DIV)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_q),
        .pre0     (pre0),
        .pre1     (pre1),
        .cmd      (cmd),
        .qstep    (qstep),
        .a_rise   (a_rise),
        .idx_rise (idx_rise),
        .gate     (pins_s[3]),
        .count    (count_q),
        .cap      (cap_q),
        .tc       (tc_q)
    );

    assign cnt_out = (mode_q.out_src ? tc_q : cap_q) ^ mode_q.out_pol;
endmodule

// File: rtl/tmr24_chk.sv
`timescale 1ns/1ps
module tmr24_chk #(
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [1:0]    addr,
    input logic [15:0]   wdata,
    input logic [15:0]   rdata,
    input logic [15:0]   mode_w,
    input logic [CW-1:0] count_w,
    input logic          cap_w,
    input logic          tc_w
);
    localparam int HI_W = CW - 16;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cap_w && count_w == '0 && mode_w == '0));

    assert_clear_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3 && wdata[15] && !wdata[14]) |=> (count_w == '0));

    assert_capclr_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3 && wdata[3]) |=> !cap_w);

    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_w[8:7] == 2'd0 && !(wr_en && addr == 2'd3) && mode_w[4:2] != 3'd4)
        |=> $stable(count_w));

    assert_term_sets_cap_R9: assert property (@(posedge clk) disable iff (rst)
        tc_w |-> cap_w);

    assert_hi_pad_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd2) |-> (rdata[15:HI_W] == '0));
endmodule

bind tmr24_core tmr24_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .mode_w  (mode_q),
    .count_w (count_q),
    .cap_w   (cap_q),
    .tc_w    (tc_q)
);

// File: tb/sim_tmr24_core.sv
`timescale 1ns/1ps
module sim_tmr24_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic        enc_idx = 1'b0;
    logic        gate_in = 1'b0;
    logic        cnt_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ph = 0;

    always #2.5 clk = ~clk;

    tmr24_core u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .enc_a (enc_a), .enc_b (enc_b), .enc_idx (enc_idx),
        .gate_in (gate_in), .cnt_out (cnt_out)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [15:0] lo;
        logic [15:0] hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = {hi[7:0], lo};
    endtask

    task automatic set_pre(input logic [23:0] v);
        wr(2'd1, v[15:0]);
        wr(2'd2, {8'h00, v[23:16]});
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(2'd0, d); chk("R1 mode", d, 0);
        rd(2'd1, d); chk("R1 count lo", d, 0);
        rd(2'd3, d); chk("R1 capture", d, 1);
        chk("R1 out", cnt_out, 1);
    endtask

    task automatic t_regs;
        logic [15:0] d;
        logic [23:0] v;
        wr(2'd0, 16'hA461); rd(2'd0, d); chk("R2 mode readback", d, 16'hA461);
        wr(2'd0, 16'h4000);
        set_pre(24'h001234);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h5678);
        wr(2'd2, 16'hFF12);
        wr(2'd3, 16'h4000);
        read_count(v); chk("R2 preload0 routing, high byte masked", v, 24'h125678);
        rd(2'd2, d); chk("R4 high word padding", d, 16'h0012);
    endtask

    task automatic t_ctrl;
        logic [23:0] v;
        wr(2'd3, 16'h8000); read_count(v); chk("R3 clear", v, 0);
        wr(2'd3, 16'hC000); read_count(v); chk("R3 load beats clear", v, 24'h125678);
    endtask

    task automatic t_oneshot;
        logic [15:0] d;
        int highs;
        wr(2'd0, 16'h1F66);
        set_pre(24'd5);
        wr(2'd3, 16'h4000);
        chk("R11 polarity idle", cnt_out, 0);
        wr(2'd3, 16'h0008);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            if (cnt_out) highs++;
            @(negedge clk);
        end
        chk("R5 R10 one-shot width", highs, 6);
        rd(2'd1, d); chk("R10 reload after one-shot", d, 5);
        rd(2'd3, d); chk("R12 capture after one-shot", d, 1);
    endtask

    task automatic t_wrap;
        logic [23:0] v;
        logic [15:0] d;
        wr(2'd0, 16'h1740);
        set_pre(24'hFFFFFD);
        wr(2'd3, 16'h4000);
        wr(2'd3, 16'h0008);
        idle(20);
        read_count(v); chk("R9 up wrap", v, 0);
        rd(2'd3, d); chk("R12 capture set", d, 1);
        wr(2'd0, 16'h1F40);
        set_pre(24'd2);
        wr(2'd3, 16'h4000);
        wr(2'd3, 16'h0008);
        idle(20);
        read_count(v); chk("R9 down wrap", v, 24'hFFFFFF);
    endtask

    task automatic t_train;
        logic [13:0] mask;
        wr(2'd0, 16'h4000);
        set_pre(24'd1);
        wr(2'd0, 16'h0000);
        set_pre(24'd3);
        wr(2'd0, 16'h1E89);
        wr(2'd3, 16'h4000);
        mask = '0;
        for (int i = 0; i < 14; i++) begin
            mask[i] = cnt_out;
            @(negedge clk);
        end
        chk("R10 R11 pulse train positions", mask, 14'h1450);
    endtask

    task automatic t_index;
        logic [23:0] v;
        logic [15:0] d;
        wr(2'd0, 16'h0010);
        set_pre(24'h000077);
        wr(2'd3, 16'h8008);
        rd(2'd3, d); chk("R12 capture cleared", d, 0);
        read_count(v); chk("R3 cleared before index", v, 0);
        enc_idx = 1'b1; idle(5); enc_idx = 1'b0; idle(5);
        read_count(v); chk("R10 index reload", v, 24'h77);
    endtask

    task automatic t_latch;
        logic [23:0] v;
        logic [15:0] lo;
        logic [15:0] hi;
        wr(2'd0, 16'h2000);
        set_pre(24'h0201AB);
        enc_idx = 1'b1; idle(5); enc_idx = 1'b0; idle(5);
        wr(2'd3, 16'h4000);
        read_count(v); chk("R4 index snapshot", v, 24'h77);
        wr(2'd0, 16'h0000);
        read_count(v); chk("R4 read snapshot", v, 24'h0201AB);
        wr(2'd0, 16'h0000);
        set_pre(24'h00FFF0);
        wr(2'd0, 16'h1680);
        wr(2'd3, 16'h4000);
        rd(2'd1, lo);
        chk("R6 up count near carry", lo[15:4], 12'hFFF);
        idle(40);
        rd(2'd2, hi); chk("R4 high from old snapshot", hi, 16'h0000);
        rd(2'd1, lo);
        rd(2'd2, hi); chk("R4 high from new snapshot", hi, 16'h0001);
    endtask

    task automatic t_enable;
        logic [15:0] a;
        logic [15:0] b;
        gate_in = 1'b0;
        wr(2'd0, 16'h1700);
        wr(2'd3, 16'h8000);
        idle(20);
        rd(2'd1, a); chk("R5 gate low holds", a, 0);
        gate_in = 1'b1; idle(10); gate_in = 1'b0; idle(10);
        rd(2'd1, a); idle(10); rd(2'd1, b);
        chk("R5 gate counted", (a != 0), 1);
        chk("R5 gate low stops", b, a);
        wr(2'd0, 16'h1720);
        rd(2'd1, a); idle(10); rd(2'd1, b);
        chk("R5 inverted gate runs", (b != a), 1);
        wr(2'd0, 16'h1600);
        rd(2'd1, a); idle(10); rd(2'd1, b);
        chk("R5 disabled holds", b, a);
    endtask

    function automatic logic [1:0] gray(input int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic qmove(input int dlt);
        ph = (ph + dlt) & 3;
        {enc_a, enc_b} = gray(ph);
        idle(6);
    endtask

    task automatic t_quad;
        logic [15:0] d;
        wr(2'd0, 16'h0480);
        wr(2'd3, 16'h8000);
        for (int i = 0; i < 8; i++) qmove(1);
        rd(2'd1, d); chk("R7 x4 forward", d, 8);
        for (int i = 0; i < 3; i++) qmove(-1);
        rd(2'd1, d); chk("R7 x4 reverse", d, 5);
        qmove(2);
        rd(2'd1, d); chk("R7 illegal jump ignored", d, 5);
        wr(2'd0, 16'h0080);
        wr(2'd3, 16'h8000);
        for (int i = 0; i < 8; i++) qmove(1);
        rd(2'd1, d); chk("R7 x1 forward", d, 2);
        wr(2'd0, 16'h0280);
        wr(2'd3, 16'h8000);
        for (int i = 0; i < 8; i++) qmove(1);
        rd(2'd1, d); chk("R7 x2 forward", d, 4);
    endtask

    task automatic t_ext;
        logic [15:0] d;
        wr(2'd0, 16'h1080);
        enc_a = 1'b0; enc_b = 1'b0; idle(6);
        wr(2'd3, 16'h8000);
        for (int i = 0; i < 3; i++) begin
            enc_a = 1'b1; idle(6); enc_a = 1'b0; idle(6);
        end
        rd(2'd1, d); chk("R8 external up", d, 3);
        wr(2'd0, 16'h1880);
        enc_a = 1'b1; idle(6); enc_a = 1'b0; idle(6);
        rd(2'd1, d); chk("R8 external down", d, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_ctrl;
        t_oneshot;
        t_wrap;
        t_train;
        t_index;
        t_latch;
        t_enable;
        t_quad;
        t_ext;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
            $finish;
        end
    end
endmodule